// File: doc/BRIEF.md
# Upper-Memory Bank Soft-Switch Controller

This block sits on the address bus of an 8-bit processor system. It holds a four-flag state that tells the rest of the memory system how to serve the upper address space. The flags choose whether reads there return RAM or ROM, whether writes there reach RAM, which of two 4 KB banks backs the lower window of that space, and whether the zero page and stack come from the alternate RAM. The block changes the state only when the processor touches a set of soft-switch addresses. Reads in a 16-byte switch group set the three upper-memory flags. Writes to two dedicated addresses set or clear the alternate zero-page flag.

Write enable is protected against stray accesses. An odd switch offset takes effect only when the same address was also the address of the previous bus cycle. The block keeps that previous address itself. It also decodes three status addresses and places the matching flag in bit 7 of a status data byte. The memory arrays, the address translation and the processor are all outside the block.

Top module: `lc_bank_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `flags` is 4'b0000 (ROM read, RAM write off, bank 1, main zero page) and `status_data` is 0x00. Bit order of `flags`: [0] RAM read, [1] RAM write, [2] bank 2 select, [3] alternate zero page.
- R2: A read of switch offset 0x0, 0x2, 0x8 or 0xA (group base 0xC080) sets `flags[2:0]` on the next clock edge, to 3'b101, 3'b100, 3'b001 and 3'b000 respectively, in the order {bank2, write, read}.
- R3: A read of odd offset 0x1, 0x3, 0x9 or 0xB leaves `flags` unchanged when the previous bus cycle had a different address.
- R4: A read of odd offset 0x1, 0x3, 0x9 or 0xB whose address equals the previous bus cycle address sets `flags[2:0]` to 3'b110, 3'b111, 3'b010 and 3'b011 respectively. A further identical read keeps that value.
- R5: The previous-address register loads on every read or write cycle, and only then. Cycles with neither strobe leave it unchanged, so idle cycles between two identical reads still qualify them.
- R6: Reads of switch offsets 0x4–0x7 and 0xC–0xF, and writes anywhere in the switch group, do not change `flags`.
- R7: During a read, `status_data` is {flags[2],7'b0} at 0xC011, {flags[0],7'b0} at 0xC012 and {flags[3],7'b0} at 0xC016. It is 0x00 for any other address and whenever no read is active. It reflects the state before the clock edge.
- R8: A write of any data to 0xC008 sets `flags[3]` on the next edge, and a write to 0xC009 clears it.
- R9: Switch-group reads never change `flags[3]`. Writes never change `flags[2:0]`.
- R10: If `rd` and `wr` are both high in one cycle, the cycle is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address of the current cycle |
| rd | input | 1 | Read strobe for the current cycle |
| wr | input | 1 | Write strobe for the current cycle |
| flags | output | 4 | Bank state {altzp, bank2, ram_wr, ram_rd} |
| status_data | output | 8 | Status byte for reads of the status addresses |

## Verification
Random traffic is weighted toward the switch group, toward repeating the previous address, and toward the status and zero-page addresses. Idle cycles and writes are mixed in, so that double reads are qualified and broken in every way R5 allows. Directed sequences test an isolated odd read against a back-to-back one, a third repeat, a double read split by idle cycles, a write that breaks the repeat, and a cycle with both strobes high. Checking the status byte on every vector separates a correct flag from a neighbouring one, and confirms the zero output on non-status and non-read cycles.

// File: rtl/lc_bank_ctrl.sv
module lc_bank_ctrl #(
  parameter int          AW         = 16,
  parameter logic [15:0] SW_BASE    = 16'hC080,
  parameter logic [15:0] ZP_SET     = 16'hC008,
  parameter logic [15:0] ZP_CLR     = 16'hC009,
  parameter logic [15:0] ST_BANK2   = 16'hC011,
  parameter logic [15:0] ST_RAMRD   = 16'hC012,
  parameter logic [15:0] ST_ALTZP   = 16'hC016
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic [3:0]    flags,
  output logic [7:0]    status_data
);

  localparam int GRP_W = AW - 4;

  logic [AW-1:0] prev_q;
  logic          ram_rd_q, ram_wr_q, bank2_q, altzp_q;

  logic          rd_cyc, wr_cyc, bus_cyc;
  logic          in_grp, grp_hit, grp_odd, repeat_ok;
  logic [3:0]    off;

  assign rd_cyc  = rd;
  assign wr_cyc  = wr & ~rd;
  assign bus_cyc = rd_cyc | wr_cyc;

  assign off     = addr[3:0];
  assign in_grp  = addr[AW-1:4] == SW_BASE[AW-1:4];
  assign grp_hit = rd_cyc & in_grp & ~off[2];
  assign grp_odd = off[0];
  assign repeat_ok = prev_q == addr;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else if (bus_cyc) prev_q <= addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_rd_q <= 1'b0;
      ram_wr_q <= 1'b0;
      bank2_q  <= 1'b0;
    end else if (grp_hit && (!grp_odd || repeat_ok)) begin
      ram_rd_q <= off[0] == off[1];
      ram_wr_q <= grp_odd;
      bank2_q  <= ~off[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) altzp_q <= 1'b0;
    else if (wr_cyc && addr == ZP_SET[AW-1:0]) altzp_q <= 1'b1;
    else if (wr_cyc && addr == ZP_CLR[AW-1:0]) altzp_q <= 1'b0;
  end

  assign flags = {altzp_q, bank2_q, ram_wr_q, ram_rd_q};

  always_comb begin
    status_data = 8'h00;
    if (rd_cyc) begin
      if (addr == ST_BANK2[AW-1:0]) status_data = {bank2_q, 7'b0};
      else if (addr == ST_RAMRD[AW-1:0]) status_data = {ram_rd_q, 7'b0};
      else if (addr == ST_ALTZP[AW-1:0]) status_data = {altzp_q, 7'b0};
    end
  end

endmodule

module lc_bank_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic          wr,
  input logic [3:0]    flags,
  input logic [7:0]    status_data,
  input logic [AW-1:0] prev_q
);

  logic grp_sel;
  assign grp_sel = addr[AW-1:4] == 12'hC08;

  a_r3_isolated_odd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && grp_sel && addr[0] && !addr[2] && addr != prev_q) |=> $stable(flags));

  a_r4_write_needs_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[1] && !(rd && grp_sel && addr[0] && addr == prev_q)) |=> !flags[1]);

  a_r6_unused_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && grp_sel && addr[2]) |=> $stable(flags));

  a_r8_altzp_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && addr == 16'hC008) |=> flags[3]);

  a_r8_altzp_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && addr == 16'hC009) |=> !flags[3]);

  a_r9_write_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd) |=> $stable(flags[2:0]));

  a_r9_read_keeps_altzp: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> $stable(flags[3]));

  a_r7_status_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> status_data == 8'h00);

  a_r7_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_data[6:0] == 7'b0);

endmodule

bind lc_bank_ctrl lc_bank_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
  .flags(flags), .status_data(status_data), .prev_q(prev_q)
);

// File: tb/sim_lc_bank_ctrl.sv
module sim_lc_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [3:0]  flags;
  logic [7:0]  status_data;

  int n_chk = 0, n_bad = 0;
  logic [3:0]  m_flags;
  logic [15:0] m_prev;
  bit          done = 0;

  always #10 clk = ~clk;

  lc_bank_ctrl u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
                   .flags(flags), .status_data(status_data));

  function automatic logic [7:0] exp_status(logic [15:0] a, logic r, logic [3:0] f);
    if (!r) return 8'h00;
    case (a)
      16'hC011: return {f[2], 7'b0};
      16'hC012: return {f[0], 7'b0};
      16'hC016: return {f[3], 7'b0};
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_next(logic [15:0] a, logic r, logic w,
                                          logic [15:0] p, logic [3:0] f);
    logic [3:0] n = f;
    if (r) begin
      if (a[15:4] == 12'hC08) begin
        case (a[3:0])
          4'h0: n[2:0] = 3'b101;
          4'h2: n[2:0] = 3'b100;
          4'h8: n[2:0] = 3'b001;
          4'hA: n[2:0] = 3'b000;
          4'h1: if (a == p) n[2:0] = 3'b110;
          4'h3: if (a == p) n[2:0] = 3'b111;
          4'h9: if (a == p) n[2:0] = 3'b010;
          4'hB: if (a == p) n[2:0] = 3'b011;
          default: ;
        endcase
      end
    end else if (w) begin
      if (a == 16'hC008) n[3] = 1'b1;
      if (a == 16'hC009) n[3] = 1'b0;
    end
    return n;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [15:0] a, logic r, logic w, string tag);
    addr = a; rd = r; wr = w;
    #1;
    check({tag, " R7 status"}, status_data, exp_status(a, r, m_flags));
    @(posedge clk);
    m_flags = exp_next(a, r, w, m_prev, m_flags);
    if (r || w) m_prev = a;
    @(negedge clk);
    check({tag, " flags"}, {4'b0, flags}, {4'b0, m_flags});
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_flags = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", {4'b0, flags}, 8'h00);
    rd = 1; addr = 16'hC016; #1;
    check("R1 reset status", status_data, 8'h00);
    rd = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 after release", {4'b0, flags}, 8'h00);

    cyc(16'hC080, 1, 0, "R2 off0");
    cyc(16'hC011, 1, 0, "R7 bank2");
    cyc(16'hC012, 1, 0, "R7 ramrd");
    cyc(16'hC08A, 1, 0, "R2 offA");
    cyc(16'hC081, 1, 0, "R3 single 1");
    cyc(16'hC081, 1, 0, "R4 double 1");
    cyc(16'hC081, 1, 0, "R4 triple 1");
    cyc(16'hC08B, 1, 0, "R3 single B");
    cyc(16'h0000, 0, 0, "R5 idle");
    cyc(16'h0000, 0, 0, "R5 idle");
    cyc(16'hC08B, 1, 0, "R5 idle gap B");
    cyc(16'hC089, 1, 0, "R3 single 9");
    cyc(16'hC089, 0, 1, "R6 write group");
    cyc(16'hC089, 1, 0, "R5 write counts 9");
    cyc(16'hC083, 1, 0, "R3 single 3");
    cyc(16'hC003, 0, 1, "R5 break");
    cyc(16'hC083, 1, 0, "R5 broken 3");
    cyc(16'hC083, 1, 0, "R4 double 3");
    cyc(16'hC085, 1, 0, "R6 off5");
    cyc(16'hC08E, 1, 0, "R6 offE");
    cyc(16'hC008, 0, 1, "R8 set");
    cyc(16'hC016, 1, 0, "R7 altzp");
    cyc(16'hC088, 1, 0, "R9 read keeps altzp");
    cyc(16'hC009, 0, 1, "R8 clr");
    cyc(16'hC008, 1, 1, "R10 both strobes");
    cyc(16'hC082, 1, 0, "R2 off2");

    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 99);
      logic [15:0] a;
      logic r, w;
      if (k < 40)      a = {12'hC08, 4'($urandom_range(0, 15))};
      else if (k < 60) a = m_prev;
      else if (k < 75) a = 16'hC010 + 16'($urandom_range(0, 7));
      else if (k < 85) a = $urandom_range(0, 1) ? 16'hC008 : 16'hC009;
      else             a = 16'($urandom);
      k = $urandom_range(0, 99);
      r = k < 65 || k >= 95;
      w = k >= 65;
      if (k >= 85 && k < 95) begin r = 0; w = 0; end
      cyc(a, r, w, "R4 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule